// File: doc/BRIEF.md
# Station Address Clock-Crossing Register

This block holds one 48-bit station address written from a host bus clock and delivers it, as a single coherent value, into an independent line-side clock domain. Software sees two registers: a 16-bit upper word and a 32-bit lower word. Both take byte-enabled writes and can be read back at any time. Reads always return the most recent writes, whether or not those values have reached the line side yet.

Only one byte lane of the lower word arms a transfer to the line side. An endianness input picks that lane. With the little-endian setting it is byte lane 3 (bits [31:24]). With the big-endian setting it is byte lane 0 (bits [7:0]). A write that arms a transfer does three things on the same host edge:
- It captures the complete 48-bit value, including that write's own bytes, into a holding register.
- It flips a toggle flag.
- It sends the toggle through a two-flop synchronizer.

When the line domain sees the synchronized toggle change, it loads all 48 bits at once and raises a one-cycle update pulse.

Register writes are single-cycle and are never back-pressured, so the host port has no ready signal. The host must space arming writes at least four line-clock cycles apart. The line-side address output is a plain status vector; the update pulse marks each new value.

Top module: `stn_addr_cdc`

## Requirements
- R1: After reset, the upper word reads 16'hFFFF, the lower word reads 32'hFFFFFFFF, the line-side address is all ones and the update pulse is low.
- R2: A write changes only the bytes whose enables are set. Enable bit n covers data bits [8n+7:8n]. The upper word takes only lanes 0 and 1, and its lanes 2 and 3 are ignored. The read-select input chooses the word (0 = lower, 1 = upper). An upper read is zero-extended to 32 bits.
- R3: Writes to the upper word, and writes to the lower word that miss the arming lane, leave the line-side address and the update pulse unchanged.
- R4: With the endianness input low (little-endian), a lower-word write with enable bit 3 set arms a transfer.
- R5: With the endianness input high (big-endian), a lower-word write with enable bit 0 set arms a transfer. In this mode, enable bit 3 alone does not arm a transfer.
- R6: After an arming write, the line-side address equals {upper, lower} as they stood after that write. It appears within 4 line-clock cycles of the host edge that accepted the write. All 48 bits change in one line cycle, and no mixed value is ever shown.
- R7: A write after the arming write changes the readback at once but not the line-side address.
- R8: Each completed transfer produces exactly one single-cycle update pulse in the line domain, in the cycle the new address appears.
- R9: Arming writes spaced at least four line cycles apart are each delivered, in order, and the line side ends up holding the last one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hst_clk | input | 1 | Host bus clock |
| hst_rst_n | input | 1 | Host-domain asynchronous reset, active low |
| hst_wr_en | input | 1 | Register write strobe, one cycle per write |
| hst_wr_sel | input | 1 | Write target: 0 = lower word, 1 = upper word |
| hst_wr_be | input | 4 | Byte enables for the write |
| hst_wr_data | input | 32 | Write data |
| hst_big_endian | input | 1 | Arming-lane select: 0 = lane 3, 1 = lane 0 |
| hst_rd_sel | input | 1 | Read target: 0 = lower word, 1 = upper word |
| hst_rd_data | output | 32 | Combinational readback of the selected word |
| ln_clk | input | 1 | Line-side clock |
| ln_rst_n | input | 1 | Line-domain asynchronous reset, active low |
| ln_station_addr | output | 48 | Station address in the line domain |
| ln_addr_upd | output | 1 | One-cycle pulse when the line-side address loads |

## Verification
Readback is combinational, so each read is sampled 1 ns after the read select settles, and the write it reflects was accepted on the preceding host edge. The new line-side address follows the accepting host edge by three line-clock edges: two synchronizer flops and then the load. The bench waits six full line cycles before it samples at a falling line edge, which leaves margin for the unrelated clock phase. Tests of writes that must not propagate wait eight line cycles before checking that the address and the pulse count are unchanged. A monitor on every line cycle flags any change of the address to a value other than the one expected from the latest arming write.

// File: rtl/stn_addr_pkg.sv
package stn_addr_pkg;

  typedef enum logic {
    WORD_LOWER = 1'b0,
    WORD_UPPER = 1'b1
  } word_sel_e;

  localparam int unsigned LANE_W = 8;

endpackage

// File: rtl/stn_sync_chain.sv
module stn_sync_chain #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_out = chain_q[STAGES-1];

endmodule

// File: rtl/stn_host_regs.sv
module stn_host_regs
  import stn_addr_pkg::*;
#(
  parameter int unsigned UPPER_W  = 16,
  parameter int unsigned LOWER_W  = 32,
  parameter logic [UPPER_W+LOWER_W-1:0] RST_ADDR = '1,
  localparam int unsigned ADDR_W  = UPPER_W + LOWER_W,
  localparam int unsigned LOW_LN  = LOWER_W / LANE_W,
  localparam int unsigned UP_LN   = UPPER_W / LANE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  word_sel_e          wr_sel,
  input  logic [LOW_LN-1:0]  wr_be,
  input  logic [LOWER_W-1:0] wr_data,
  input  logic               big_endian,
  input  word_sel_e          rd_sel,
  output logic [LOWER_W-1:0] rd_data,
  output logic [ADDR_W-1:0]  hold_addr,
  output logic               xfer_tog
);

  logic [UPPER_W-1:0] upper_q, upper_n;
  logic [LOWER_W-1:0] lower_q, lower_n;
  logic               arm;
  logic               arm_lane_hit;

  generate
    for (genvar ln = 0; ln < LOW_LN; ln++) begin : g_low_lane
      always_comb begin
        if (wr_en && wr_sel == WORD_LOWER && wr_be[ln])
          lower_n[ln*LANE_W +: LANE_W] = wr_data[ln*LANE_W +: LANE_W];
        else
          lower_n[ln*LANE_W +: LANE_W] = lower_q[ln*LANE_W +: LANE_W];
      end
    end
    for (genvar ln = 0; ln < UP_LN; ln++) begin : g_up_lane
      always_comb begin
        if (wr_en && wr_sel == WORD_UPPER && wr_be[ln])
          upper_n[ln*LANE_W +: LANE_W] = wr_data[ln*LANE_W +: LANE_W];
        else
          upper_n[ln*LANE_W +: LANE_W] = upper_q[ln*LANE_W +: LANE_W];
      end
    end
  endgenerate

  assign arm_lane_hit = big_endian ? wr_be[0] : wr_be[LOW_LN-1];
  assign arm          = wr_en && (wr_sel == WORD_LOWER) && arm_lane_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q   <= RST_ADDR[ADDR_W-1 -: UPPER_W];
      lower_q   <= RST_ADDR[LOWER_W-1:0];
      hold_addr <= RST_ADDR;
      xfer_tog  <= 1'b0;
    end else begin
      upper_q <= upper_n;
      lower_q <= lower_n;
      if (arm) begin
        hold_addr <= {upper_n, lower_n};
        xfer_tog  <= ~xfer_tog;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_sel == WORD_UPPER) rd_data[UPPER_W-1:0] = upper_q;
    else                      rd_data = lower_q;
  end

  AST_ARM_FLIPS_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> xfer_tog != $past(xfer_tog)); // R4
  AST_IDLE_TOGGLE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> $stable(xfer_tog)); // R3
  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> $stable(hold_addr)); // R7
  AST_BE_LANE3_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && big_endian && wr_be == 4'b1000) |=> $stable(xfer_tog)); // R5

endmodule

// File: rtl/stn_line_load.sv
module stn_line_load #(
  parameter int unsigned ADDR_W = 48,
  parameter logic [ADDR_W-1:0] RST_ADDR = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tog_sync,
  input  logic [ADDR_W-1:0] hold_addr,
  output logic [ADDR_W-1:0] station_addr,
  output logic              addr_upd
);

  logic tog_seen;
  logic tog_edge;

  assign tog_edge = tog_sync ^ tog_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_seen     <= 1'b0;
      station_addr <= RST_ADDR;
      addr_upd     <= 1'b0;
    end else begin
      tog_seen <= tog_sync;
      addr_upd <= tog_edge;
      if (tog_edge) station_addr <= hold_addr;
    end
  end

  AST_ADDR_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !tog_edge |=> $stable(station_addr)); // R6
  AST_LOAD_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
    tog_edge |=> station_addr == $past(hold_addr)); // R6
  AST_PULSE_WITH_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tog_sync) |=> addr_upd); // R8

endmodule

// File: rtl/stn_addr_cdc.sv
module stn_addr_cdc
  import stn_addr_pkg::*;
#(
  parameter int unsigned UPPER_W     = 16,
  parameter int unsigned LOWER_W     = 32,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned ADDR_W     = UPPER_W + LOWER_W,
  localparam int unsigned LOW_LN     = LOWER_W / LANE_W
) (
  input  logic               hst_clk,
  input  logic               hst_rst_n,
  input  logic               hst_wr_en,
  input  logic               hst_wr_sel,
  input  logic [LOW_LN-1:0]  hst_wr_be,
  input  logic [LOWER_W-1:0] hst_wr_data,
  input  logic               hst_big_endian,
  input  logic               hst_rd_sel,
  output logic [LOWER_W-1:0] hst_rd_data,
  input  logic               ln_clk,
  input  logic               ln_rst_n,
  output logic [ADDR_W-1:0]  ln_station_addr,
  output logic               ln_addr_upd
);

  localparam logic [ADDR_W-1:0] RST_ADDR = '1;

  logic [ADDR_W-1:0] hold_addr;
  logic              xfer_tog;
  logic              tog_sync;

  stn_host_regs #(
    .UPPER_W (UPPER_W),
    .LOWER_W (LOWER_W),
    .RST_ADDR(RST_ADDR)
  ) u_host (
    .clk       (hst_clk),
    .rst_n     (hst_rst_n),
    .wr_en     (hst_wr_en),
    .wr_sel    (word_sel_e'(hst_wr_sel)),
    .wr_be     (hst_wr_be),
    .wr_data   (hst_wr_data),
    .big_endian(hst_big_endian),
    .rd_sel    (word_sel_e'(hst_rd_sel)),
    .rd_data   (hst_rd_data),
    .hold_addr (hold_addr),
    .xfer_tog  (xfer_tog)
  );

  stn_sync_chain #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk  (ln_clk),
    .rst_n(ln_rst_n),
    .d_in (xfer_tog),
    .q_out(tog_sync)
  );

  stn_line_load #(
    .ADDR_W  (ADDR_W),
    .RST_ADDR(RST_ADDR)
  ) u_line (
    .clk         (ln_clk),
    .rst_n       (ln_rst_n),
    .tog_sync    (tog_sync),
    .hold_addr   (hold_addr),
    .station_addr(ln_station_addr),
    .addr_upd    (ln_addr_upd)
  );

endmodule

// File: tb/tb_stn_addr_cdc.sv
`timescale 1ns/1ps
module tb_stn_addr_cdc;

  logic        hst_clk = 0, ln_clk = 0;
  logic        hst_rst_n = 0, ln_rst_n = 0;
  logic        wr_en = 0, wr_sel = 0, big_endian = 0, rd_sel = 0;
  logic [3:0]  wr_be = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [47:0] ln_addr;
  logic        ln_upd;

  int checks = 0, fails = 0, upd_cnt = 0, mix_err = 0;
  logic [47:0] exp_line = '1, last_seen = '1;

  always #2    hst_clk = ~hst_clk;  // 250 MHz
  always #3.65 ln_clk  = ~ln_clk;   // unrelated line clock

  stn_addr_cdc dut (
    .hst_clk(hst_clk), .hst_rst_n(hst_rst_n), .hst_wr_en(wr_en),
    .hst_wr_sel(wr_sel), .hst_wr_be(wr_be), .hst_wr_data(wr_data),
    .hst_big_endian(big_endian), .hst_rd_sel(rd_sel), .hst_rd_data(rd_data),
    .ln_clk(ln_clk), .ln_rst_n(ln_rst_n),
    .ln_station_addr(ln_addr), .ln_addr_upd(ln_upd)
  );

  always @(negedge ln_clk) begin
    if (ln_rst_n) begin
      if (ln_upd) upd_cnt++;
      if (ln_addr !== last_seen && ln_addr !== exp_line) mix_err++;
      last_seen = ln_addr;
    end
  end

  task automatic check(string req, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_write(logic sel, logic [3:0] be, logic [31:0] d);
    @(negedge hst_clk);
    wr_en = 1; wr_sel = sel; wr_be = be; wr_data = d;
    @(negedge hst_clk);
    wr_en = 0; wr_be = 0;
  endtask

  task automatic read_word(logic sel, output logic [31:0] v);
    @(negedge hst_clk);
    rd_sel = sel;
    #1 v = rd_data;
  endtask

  task automatic line_wait(int n);
    repeat (n) @(posedge ln_clk);
    @(negedge ln_clk);
    #0.1;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    read_word(1, v); check("R1 upper", {16'h0, v}, 48'h0000_0000_FFFF);
    read_word(0, v); check("R1 lower", {16'h0, v}, 48'h0000_FFFF_FFFF);
    check("R1 line addr", ln_addr, 48'hFFFF_FFFF_FFFF);
    check("R1 upd", {47'h0, ln_upd}, 48'h0);
  endtask

  task automatic t_lanes();
    logic [31:0] v;
    int u0 = upd_cnt;
    host_write(1, 4'b0011, 32'h0000_A1B2);
    read_word(1, v); check("R2 upper lanes", {16'h0, v}, 48'h0000_0000_A1B2);
    host_write(1, 4'b1100, 32'h5566_0000);
    read_word(1, v); check("R2 upper lanes 2-3 ignored", {16'h0, v}, 48'h0000_0000_A1B2);
    host_write(0, 4'b0111, 32'h0033_4455);
    read_word(0, v); check("R2 lower partial", {16'h0, v}, 48'h0000_FF33_4455);
    line_wait(8);
    check("R3 no-arm lanes", ln_addr, 48'hFFFF_FFFF_FFFF);
    check("R3 no pulse", 48'(upd_cnt - u0), 48'h0);
  endtask

  task automatic t_le_arm();
    logic [31:0] v;
    int u0 = upd_cnt;
    exp_line = 48'hA1B2_1133_4455;
    host_write(0, 4'b1000, 32'h1100_0000);
    read_word(0, v); check("R4 lower readback", {16'h0, v}, 48'h0000_1133_4455);
    line_wait(6);
    check("R4 R6 line addr", ln_addr, exp_line);
    check("R8 one pulse", 48'(upd_cnt - u0), 48'h1);
  endtask

  task automatic t_upper_only();
    logic [31:0] v;
    host_write(1, 4'b0011, 32'h0000_C3D4);
    read_word(1, v); check("R7 readback", {16'h0, v}, 48'h0000_0000_C3D4);
    line_wait(8);
    check("R7 R3 line unchanged", ln_addr, 48'hA1B2_1133_4455);
  endtask

  task automatic t_be_arm();
    logic [31:0] v;
    int u0;
    big_endian = 1;
    host_write(0, 4'b1000, 32'h2200_0000);
    line_wait(8);
    check("R5 lane3 quiet", ln_addr, 48'hA1B2_1133_4455);
    u0 = upd_cnt;
    exp_line = 48'hC3D4_2233_4466;
    host_write(0, 4'b0001, 32'h0000_0066);
    read_word(0, v); check("R5 lower readback", {16'h0, v}, 48'h0000_2233_4466);
    line_wait(6);
    check("R5 R6 line addr", ln_addr, exp_line);
    check("R8 one pulse be", 48'(upd_cnt - u0), 48'h1);
  endtask

  task automatic t_spaced();
    int u0 = upd_cnt;
    big_endian = 0;
    exp_line = 48'hC3D4_7733_4466;
    host_write(0, 4'b1000, 32'h7700_0000);
    repeat (10) @(posedge hst_clk);
    exp_line = 48'hC3D4_8833_4466;
    host_write(0, 4'b1000, 32'h8800_0000);
    line_wait(6);
    check("R9 last value", ln_addr, exp_line);
    check("R9 two pulses", 48'(upd_cnt - u0), 48'h2);
    check("R6 never mixed", 48'(mix_err), 48'h0);
  endtask

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #20;
    hst_rst_n = 1; ln_rst_n = 1;
    line_wait(2);
    t_reset();
    t_lanes();
    t_le_arm();
    t_upper_only();
    t_be_arm();
    t_spaced();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule